// File: doc/BRIEF.md
# Multi-Queue Cell Buffer with Head and Tail Caches

This block keeps a set of independent FIFO queues of fixed-size cells and gives each of them an ideal FIFO interface, even though the bulk of every queue sits in a wide, slow memory. In each clock slot the block takes at most one arriving cell, tagged with its queue index, and at most one departure request, also tagged with a queue index. Every queue has three places to hold cells. A small tail cache gathers new cells. A bulk region holds whole blocks of `BLK` cells. A small head cache holds the oldest cells and serves departures.

The bulk memory can take one whole-block write and give one whole-block read in each window of `BLK` slots. The write moves a full block from some tail cache. The read refills the head cache of the queue that the pending requests will drain soonest. When a queue has no blocks in bulk memory, its tail cells move straight into its head cache, one cell per slot. Every accepted request waits in a lookahead pipeline of `LAT = NQ*(BLK-1)+1` slots. The scheduler uses those pending requests to decide which queue to refill, so every cell is ready in its head cache by the time its request comes out of the pipeline.

Top module: `hbuf_top`

## Requirements
- R1: While `rstN` is low and after it is released, all queues are empty and `outValid`, `reqErr` and `inErr` are 0 until a stimulus produces them.
- R2: For each queue, cells leave in the order in which their arrivals were accepted. No cell is lost or duplicated.
- R3: A request accepted at clock edge n gives `outValid`=1 after edge n+LAT, with `outQueue` equal to the requested queue. No departure appears without a request.
- R4: A request for a queue that holds no unrequested cell is rejected. `reqErr` is 1 after that edge, no departure follows, and the queue's later departures are unaffected.
- R5: An arrival for a queue whose tail cache already holds `TCAP` cells is rejected. `inErr` is 1 after that edge and the cells already stored stay intact. With the defaults (`HCAP`=8, `BDEP`=4 blocks of 4, `TCAP`=8), a queue that gets back-to-back arrivals and no requests accepts exactly 32 cells and rejects the 33rd.
- R6: The bulk memory gets at most one block write and at most one block read in any `BLK` consecutive slots. A block write always carries `BLK` cells from a single tail cache.
- R7: With one arrival and one request per slot spread over all queues, every accepted request is served on time and no head cache goes beyond `HCAP` cells.
- R8: A queue that holds only a few cells, none of them in bulk memory, still serves a request at the fixed latency, because tail cells move directly to the head cache.
- R9: An arrival and a request in the same slot for the same queue: the request does not count that arrival when it decides whether the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An arriving cell is present |
| inQueue | input | QW | Queue index of the arriving cell |
| inCell | input | W | Arriving cell data |
| reqValid | input | 1 | A departure request is present |
| reqQueue | input | QW | Queue index of the request |
| outValid | output | 1 | A departing cell is present |
| outQueue | output | QW | Queue index of the departing cell |
| outCell | output | W | Departing cell data |
| reqErr | output | 1 | Previous request was rejected (queue empty) |
| inErr | output | 1 | Previous arrival was rejected (tail cache full) |

## Verification
Assertions check four things on every cycle. A departing queue always holds a cell in its head cache. A bypass move always has a tail cell to take. Block writes and block reads keep to the one-per-window rate, and writes move whole blocks. Cache occupancy stays within its bounds. Ordering, exact latency, rejection without corruption, the same-slot arrival and request rule, and the exact capacity of a full queue can only be shown by the bench scenarios. There, a model of ideal FIFOs predicts every output slot by slot.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
  // Per-slot strobes from control to datapath
  typedef struct packed {
    logic arrWe;   // accepted arrival written into a tail cache
    logic bulkWr;  // one tail block moved into bulk memory
    logic bulkRd;  // one bulk block moved into a head cache
    logic byp;     // one tail cell moved straight into a head cache
    logic dep;     // one head cell leaves
  } hbufStrobe_t;
endpackage

// File: rtl/hbuf_ctrl.sv
module hbuf_ctrl
  import hbuf_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int BLK  = 4,
  parameter int HCAP = 8,
  parameter int TCAP = 8,
  parameter int BDEP = 4,
  parameter int LAT  = 13,
  parameter int QW   = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          arrV,
  input  logic [QW-1:0] arrQ,
  input  logic          reqV,
  input  logic [QW-1:0] reqQ,
  output hbufStrobe_t   st,
  output logic [QW-1:0] wrQ,
  output logic [QW-1:0] rdQ,
  output logic [QW-1:0] bypQ,
  output logic [QW-1:0] depQ,
  output logic          reqErr,
  output logic          arrErr
);
  localparam int HCW = $clog2(HCAP + 1);
  localparam int TCW = $clog2(TCAP + 1);
  localparam int BCW = $clog2(BDEP + 1);
  localparam int PCW = $clog2(LAT + 1);
  localparam int PHW = $clog2(BLK);
  localparam int GW  = $clog2(BLK + 1);

  logic [HCW-1:0] headCnt [NQ];
  logic [TCW-1:0] tailCnt [NQ];
  logic [BCW-1:0] bulkCnt [NQ];
  logic [PCW-1:0] pendCnt [NQ];
  logic           pipeV   [LAT];
  logic [QW-1:0]  pipeQ   [LAT];
  logic [PHW-1:0] phase;
  logic           slotOpen;
  logic           reqOk, arrOk;
  logic           wrHit, rdHit, bypHit;
  int             availReq, bestW, bestR, bestB, defQ;

  assign slotOpen = (phase == '0);

  // Admission of the incoming request and arrival (registered counts only)
  always_comb begin
    availReq = int'(headCnt[reqQ]) + int'(bulkCnt[reqQ]) * BLK
             + int'(tailCnt[reqQ]) - int'(pendCnt[reqQ]);
    reqOk = reqV && (availReq > 0);
    arrOk = arrV && (int'(tailCnt[arrQ]) < TCAP);
  end

  // Transfer selection: fullest tail for writes, most urgent head for reads
  always_comb begin
    wrHit = 1'b0; wrQ = '0; bestW = 0;
    rdHit = 1'b0; rdQ = '0; bestR = 0;
    bypHit = 1'b0; bypQ = '0; bestB = 0;
    defQ = 0;
    for (int q = 0; q < NQ; q++) begin
      if (slotOpen && int'(tailCnt[q]) >= BLK && int'(bulkCnt[q]) < BDEP &&
          (!wrHit || int'(tailCnt[q]) > bestW)) begin
        wrHit = 1'b1; wrQ = QW'(q); bestW = int'(tailCnt[q]);
      end
      defQ = int'(pendCnt[q]) - int'(headCnt[q]);
      if (slotOpen && bulkCnt[q] != '0 && int'(headCnt[q]) + BLK <= HCAP &&
          (!rdHit || defQ > bestR)) begin
        rdHit = 1'b1; rdQ = QW'(q); bestR = defQ;
      end
    end
    for (int q = 0; q < NQ; q++) begin
      defQ = int'(pendCnt[q]) - int'(headCnt[q]);
      if (tailCnt[q] != '0 && bulkCnt[q] == '0 && int'(headCnt[q]) < HCAP &&
          !(wrHit && wrQ == QW'(q)) && (!bypHit || defQ > bestB)) begin
        bypHit = 1'b1; bypQ = QW'(q); bestB = defQ;
      end
    end
  end

  assign depQ = pipeQ[LAT-1];

  always_comb begin
    st.arrWe  = arrOk;
    st.bulkWr = wrHit;
    st.bulkRd = rdHit;
    st.byp    = bypHit;
    st.dep    = pipeV[LAT-1];
  end

  // Occupancy bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int q = 0; q < NQ; q++) begin
        headCnt[q] <= '0; tailCnt[q] <= '0; bulkCnt[q] <= '0; pendCnt[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        headCnt[q] <= HCW'(int'(headCnt[q])
                     + ((rdHit && rdQ == QW'(q)) ? BLK : 0)
                     + ((bypHit && bypQ == QW'(q)) ? 1 : 0)
                     - ((st.dep && depQ == QW'(q)) ? 1 : 0));
        tailCnt[q] <= TCW'(int'(tailCnt[q])
                     + ((arrOk && arrQ == QW'(q)) ? 1 : 0)
                     - ((wrHit && wrQ == QW'(q)) ? BLK : 0)
                     - ((bypHit && bypQ == QW'(q)) ? 1 : 0));
        bulkCnt[q] <= BCW'(int'(bulkCnt[q])
                     + ((wrHit && wrQ == QW'(q)) ? 1 : 0)
                     - ((rdHit && rdQ == QW'(q)) ? 1 : 0));
        pendCnt[q] <= PCW'(int'(pendCnt[q])
                     + ((reqOk && reqQ == QW'(q)) ? 1 : 0)
                     - ((st.dep && depQ == QW'(q)) ? 1 : 0));
      end
    end
  end

  // Lookahead pipeline, slot phase and error flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) begin
        pipeV[i] <= 1'b0; pipeQ[i] <= '0;
      end
      phase  <= '0;
      reqErr <= 1'b0;
      arrErr <= 1'b0;
    end else begin
      pipeV[0] <= reqOk;
      pipeQ[0] <= reqQ;
      for (int i = 1; i < LAT; i++) begin
        pipeV[i] <= pipeV[i-1]; pipeQ[i] <= pipeQ[i-1];
      end
      phase  <= (phase == PHW'(BLK - 1)) ? '0 : phase + 1'b1;
      reqErr <= reqV && !reqOk;
      arrErr <= arrV && !arrOk;
    end
  end

  // Gap counters for the bulk access rate checks
  logic [GW-1:0] rdGap, wrGap;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdGap <= GW'(BLK); wrGap <= GW'(BLK);
    end else begin
      rdGap <= rdHit ? '0 : ((rdGap == GW'(BLK)) ? rdGap : rdGap + 1'b1);
      wrGap <= wrHit ? '0 : ((wrGap == GW'(BLK)) ? wrGap : wrGap + 1'b1);
    end
  end

  p_read_rate_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.bulkRd |-> int'(rdGap) >= BLK - 1);
  p_write_rate_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.bulkWr |-> int'(wrGap) >= BLK - 1);
  p_whole_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.bulkWr |-> int'(tailCnt[wrQ]) >= BLK);
  p_no_underrun_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.dep |-> headCnt[depQ] != '0);

  for (genvar g = 0; g < NQ; g++) begin : gOcc
    p_tail_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
      int'(tailCnt[g]) <= TCAP);
    p_head_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
      int'(headCnt[g]) <= HCAP);
  end
endmodule

// File: rtl/hbuf_data.sv
module hbuf_data
  import hbuf_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int BLK  = 4,
  parameter int W    = 8,
  parameter int HCAP = 8,
  parameter int TCAP = 8,
  parameter int BDEP = 4,
  parameter int QW   = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  hbufStrobe_t   st,
  input  logic [QW-1:0] arrQ,
  input  logic [W-1:0]  arrData,
  input  logic [QW-1:0] wrQ,
  input  logic [QW-1:0] rdQ,
  input  logic [QW-1:0] bypQ,
  input  logic [QW-1:0] depQ,
  output logic          outValid,
  output logic [QW-1:0] outQueue,
  output logic [W-1:0]  outCell
);
  localparam int TIW = $clog2(TCAP);
  localparam int HIW = $clog2(HCAP);
  localparam int BIW = $clog2(BDEP);
  localparam int BW  = BLK * W;

  logic [W-1:0]  tailMem [NQ][TCAP];
  logic [W-1:0]  headMem [NQ][HCAP];
  logic [BW-1:0] bulkMem [NQ][BDEP];

  // Pointers carry one extra bit so full and empty differ
  logic [TIW:0] tailWp [NQ];
  logic [TIW:0] tailRp [NQ];
  logic [HIW:0] headWp [NQ];
  logic [HIW:0] headRp [NQ];
  logic [BIW:0] bulkWp [NQ];
  logic [BIW:0] bulkRp [NQ];

  logic [BW-1:0] wrBlock, rdBlock;

  always_comb begin
    for (int i = 0; i < BLK; i++) begin
      wrBlock[i*W +: W] = tailMem[wrQ][TIW'(tailRp[wrQ][TIW-1:0] + TIW'(i))];
    end
    rdBlock = bulkMem[rdQ][bulkRp[rdQ][BIW-1:0]];
  end

  // Storage arrays (no reset)
  always_ff @(posedge clk) begin
    if (st.arrWe)
      tailMem[arrQ][tailWp[arrQ][TIW-1:0]] <= arrData;
    if (st.bulkWr)
      bulkMem[wrQ][bulkWp[wrQ][BIW-1:0]] <= wrBlock;
    if (st.bulkRd) begin
      for (int i = 0; i < BLK; i++) begin
        headMem[rdQ][HIW'(headWp[rdQ][HIW-1:0] + HIW'(i))] <= rdBlock[i*W +: W];
      end
    end
    if (st.byp)
      headMem[bypQ][headWp[bypQ][HIW-1:0]] <= tailMem[bypQ][tailRp[bypQ][TIW-1:0]];
  end

  // Pointer movement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int q = 0; q < NQ; q++) begin
        tailWp[q] <= '0; tailRp[q] <= '0;
        headWp[q] <= '0; headRp[q] <= '0;
        bulkWp[q] <= '0; bulkRp[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (st.arrWe && arrQ == QW'(q))  tailWp[q] <= tailWp[q] + 1'b1;
        if (st.bulkWr && wrQ == QW'(q)) begin
          tailRp[q] <= tailRp[q] + (TIW+1)'(BLK);
          bulkWp[q] <= bulkWp[q] + 1'b1;
        end else if (st.byp && bypQ == QW'(q)) begin
          tailRp[q] <= tailRp[q] + 1'b1;
        end
        if (st.bulkRd && rdQ == QW'(q)) begin
          headWp[q] <= headWp[q] + (HIW+1)'(BLK);
          bulkRp[q] <= bulkRp[q] + 1'b1;
        end else if (st.byp && bypQ == QW'(q)) begin
          headWp[q] <= headWp[q] + 1'b1;
        end
        if (st.dep && depQ == QW'(q))    headRp[q] <= headRp[q] + 1'b1;
      end
    end
  end

  // Departure register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outQueue <= '0;
      outCell  <= '0;
    end else begin
      outValid <= st.dep;
      outQueue <= depQ;
      outCell  <= headMem[depQ][headRp[depQ][HIW-1:0]];
    end
  end

  p_dep_present_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.dep |-> headWp[depQ] != headRp[depQ]);
  p_byp_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.byp |-> tailWp[bypQ] != tailRp[bypQ]);
  p_bulk_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.bulkRd |-> bulkWp[rdQ] != bulkRp[rdQ]);
endmodule

// File: rtl/hbuf_top.sv
module hbuf_top
  import hbuf_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int BLK  = 4,
  parameter int W    = 8,
  parameter int HCAP = 8,
  parameter int TCAP = 8,
  parameter int BDEP = 4,
  parameter int QW   = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [QW-1:0] inQueue,
  input  logic [W-1:0]  inCell,
  input  logic          reqValid,
  input  logic [QW-1:0] reqQueue,
  output logic          outValid,
  output logic [QW-1:0] outQueue,
  output logic [W-1:0]  outCell,
  output logic          reqErr,
  output logic          inErr
);
  localparam int LAT = NQ * (BLK - 1) + 1;

  hbufStrobe_t   st;
  logic [QW-1:0] wrQ, rdQ, bypQ, depQ;

  hbuf_ctrl #(
    .NQ(NQ), .BLK(BLK), .HCAP(HCAP), .TCAP(TCAP), .BDEP(BDEP), .LAT(LAT), .QW(QW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .arrV(inValid), .arrQ(inQueue), .reqV(reqValid), .reqQ(reqQueue),
    .st(st), .wrQ(wrQ), .rdQ(rdQ), .bypQ(bypQ), .depQ(depQ),
    .reqErr(reqErr), .arrErr(inErr)
  );

  hbuf_data #(
    .NQ(NQ), .BLK(BLK), .W(W), .HCAP(HCAP), .TCAP(TCAP), .BDEP(BDEP), .QW(QW)
  ) u_data (
    .clk(clk), .rstN(rstN), .st(st),
    .arrQ(inQueue), .arrData(inCell),
    .wrQ(wrQ), .rdQ(rdQ), .bypQ(bypQ), .depQ(depQ),
    .outValid(outValid), .outQueue(outQueue), .outCell(outCell)
  );
endmodule

// File: tb/test_hbuf_top.sv
module test_hbuf_top;
  localparam int NQ = 4, BLK = 4, W = 8, HCAP = 8, TCAP = 8, BDEP = 4, QW = 2;
  localparam int LAT  = NQ * (BLK - 1) + 1;
  localparam int CAPQ = HCAP + BDEP * BLK + TCAP;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, reqValid = 1'b0;
  logic [QW-1:0] inQueue = '0, reqQueue = '0;
  logic [W-1:0] inCell = '0;
  logic outValid, reqErr, inErr;
  logic [QW-1:0] outQueue;
  logic [W-1:0] outCell;

  hbuf_top #(.NQ(NQ), .BLK(BLK), .W(W), .HCAP(HCAP), .TCAP(TCAP), .BDEP(BDEP)) i_hbuf_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inQueue(inQueue), .inCell(inCell),
    .reqValid(reqValid), .reqQueue(reqQueue), .outValid(outValid), .outQueue(outQueue),
    .outCell(outCell), .reqErr(reqErr), .inErr(inErr));

  always #2 clk = ~clk;

  int total = 0, bad = 0, edgeCnt = 0;
  logic [W-1:0] cellCtr = 8'h10;
  string curReq = "R1";
  logic [W-1:0] mq [NQ][$];
  bit expV [64]; int expQ [64]; logic [W-1:0] expD [64];
  bit expRE [64]; bit expAE [64];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int inflight(input int q);
    int n = 0;
    for (int i = 0; i < 64; i++) if (expV[i] && expQ[i] == q) n++;
    return n;
  endfunction

  task automatic step(input bit aV, input int aQ, input bit rV, input int rQ);
    int s, n;
    @(negedge clk);
    s = edgeCnt % 64;
    chk(outValid == expV[s], {curReq, " R3"}, "outValid", int'(outValid), int'(expV[s]));
    if (expV[s] && outValid) begin
      chk(int'(outQueue) == expQ[s], {curReq, " R3"}, "outQueue", int'(outQueue), expQ[s]);
      chk(outCell == expD[s], {curReq, " R2"}, "outCell", int'(outCell), int'(expD[s]));
    end
    chk(reqErr == expRE[s], {curReq, " R4"}, "reqErr", int'(reqErr), int'(expRE[s]));
    chk(inErr == expAE[s], {curReq, " R5"}, "inErr", int'(inErr), int'(expAE[s]));
    expV[s] = 0; expRE[s] = 0; expAE[s] = 0;
    inValid = aV; inQueue = QW'(aQ); inCell = cellCtr;
    reqValid = rV; reqQueue = QW'(rQ);
    n = edgeCnt + 1;
    // R9: the request is judged before the same-slot arrival joins the queue
    if (rV) begin
      if (mq[rQ].size() == 0) expRE[n % 64] = 1;
      else begin
        expV[(n + LAT) % 64] = 1;
        expQ[(n + LAT) % 64] = rQ;
        expD[(n + LAT) % 64] = mq[rQ].pop_front();
      end
    end
    if (aV) begin
      if (mq[aQ].size() + inflight(aQ) >= CAPQ) expAE[n % 64] = 1;
      else mq[aQ].push_back(cellCtr);
      cellCtr = cellCtr + 1'b1;
    end
    @(posedge clk);
    edgeCnt++;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0);
  endtask

  task automatic drainAll();
    for (int q = 0; q < NQ; q++) begin
      while (mq[q].size() > 0) step(0, 0, 1, q);
    end
    idle(LAT + 2);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "R3", "watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      expV[i] = 0; expRE[i] = 0; expAE[i] = 0; expQ[i] = 0; expD[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    chk(reqErr == 1'b0 && inErr == 1'b0, "R1", "errors in reset", int'(reqErr | inErr), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1/R4: a request right after reset finds every queue empty
    curReq = "R1";
    step(0, 0, 1, 0);
    idle(2);

    // R8: a single cell reaches the head cache without bulk memory
    curReq = "R8";
    step(1, 1, 0, 0);
    step(0, 0, 1, 1);
    idle(LAT + 2);

    // R9: same-slot arrival and request on an empty queue
    curReq = "R9";
    step(1, 2, 1, 2);
    step(0, 0, 1, 2);
    idle(LAT + 2);

    // R4: rejected request leaves the queue intact
    curReq = "R4";
    step(1, 0, 0, 0);
    step(1, 0, 1, 3);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    idle(LAT + 2);

    // R2/R3: one queue, long run through bulk memory, back-to-back requests
    curReq = "R2";
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0);
    idle(6);
    for (int i = 0; i < 20; i++) step(0, 0, 1, 0);
    idle(LAT + 2);

    // R6/R7: full-rate mixed traffic over all queues
    curReq = "R7";
    for (int i = 0; i < 24; i++) step(1, i % NQ, 0, 0);
    for (int i = 0; i < 160; i++) step(1, (i * 3) % NQ, 1, (i + 1) % NQ);
    idle(LAT + 2);
    drainAll();

    // R5: fill one queue to capacity, overflow it, then read everything back
    curReq = "R5";
    for (int i = 0; i < CAPQ + 1; i++) step(1, 3, 0, 0);
    step(1, 0, 0, 0);
    drainAll();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule